// File: doc/BRIEF.md
# Key-Locked System Control Register Block

This block is the control-register slice of a processor module. It sits on a simple 32-bit bus with a byte address whose two low bits are ignored. A write strobe lasts one cycle. A read strobe returns registered data one cycle later. The block holds the main and auxiliary clock-synthesizer words, which accept writes only after a 16-bit key has been loaded into the lock register. It also holds a small control register that drives a memory-remap output, an LED output and a board-reset request. Two flag words have separate set and clear addresses. A read-only window serves a memory-module descriptor table.

A small bus state machine tracks the response owed for the previous cycle's access. Its states are `BUS_IDLE`, `BUS_RD_OK`, `BUS_RD_BAD` and `BUS_WR_BAD`. On every edge it moves as follows:
- A write to a writable register goes to `BUS_IDLE`.
- A write anywhere else goes to `BUS_WR_BAD`.
- A read with no write goes to `BUS_RD_OK` for a readable address and to `BUS_RD_BAD` otherwise.
- No strobe goes to `BUS_IDLE`.

`BUS_RD_OK` and `BUS_RD_BAD` raise read-valid. `BUS_RD_BAD` and `BUS_WR_BAD` raise the error pulse. The oscillator hardware, the remap fabric and the reset generator lie outside the block. Only their control outputs are driven.

Top module: `sysctl_regblock`

## Requirements
- R1: A read strobe with no write strobe gives `bus_rvalid` high in the next cycle, with `bus_rdata` holding the register value from before the edge. When write and read strobes coincide, the write is performed and no read-valid follows. `bus_rdata` is zero whenever `bus_rvalid` is low.
- R2: After reset the registers hold these values:
  - main oscillator word (0x08): 0x01000048
  - auxiliary oscillator word (0x1C): 0x0007FEFF
  - init word (0x24): 0x00000112
  - lock (0x14), both flag words and control (0x0C): zero, so `remap_active`=1, `led_on`=0 and `board_rst_req`=0
- R3: A write to the lock register at 0x14 stores only data bits 15:0. A read of 0x14 returns 0x0001A05F while the stored value is 0xA05F, and the stored value zero-extended otherwise.
- R4: Writes to 0x08 and 0x1C replace the whole word only while the lock holds 0xA05F. Otherwise they leave the word unchanged.
- R5: Flag word A works through three addresses: ones written to 0x30 set bits, ones written to 0x34 clear bits, and a read of 0x30 returns the word. Flag word B works the same way with 0x38 (set), 0x3C (clear) and a read at 0x38. The two flag words are independent.
- R6: Address 0x00 reads 0x411A3001, 0x04 reads 0 and 0x10 reads 0x00100000. A write to any of these is ignored and raises `bus_err`.
- R7: A write to 0x0C stores data bits 2:0, and a read of 0x0C returns them. From the next cycle, `led_on` equals bit 0 and `remap_active` equals the inverse of bit 2. Neither output changes without such a write.
- R8: A write to 0x0C with data bit 3 set makes `board_rst_req` high in exactly the next cycle. Bit 3 is not stored, and `board_rst_req` is low in every cycle that does not follow such a write.
- R9: Reads of 0x100–0x17F return byte (addr−0x100)>>2 of the descriptor table, zero-extended. Entry 0 is 0x80, entry 1 is 0x08, entry 9 is 0xA0, and entry 31 is a density code (64, 32, 16, 4 or 2 for at least 256, 128, 64, 32 MiB or less). Reads of 0x180–0x1FF return zero without error. Writes anywhere in 0x100–0x1FF raise `bus_err`.
- R10: The SDRAM word at 0x20 resets to 0x00011122 ORed with 0x10, 0x0C, 0x08 or 0x04 when `MEM_MIB` is at least 256, 128, 64 or 32 (default 128 gives 0x0001112E). It and the init word at 0x24 are fully readable and writable.
- R11: Any other address, including 0x18, 0x28, a read of 0x34 or 0x3C, and anything at or above 0x200, changes nothing. `bus_err` pulses high in the next cycle. A read there also returns zero with `bus_rvalid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_rd | input | 1 | Single-cycle read strobe |
| bus_addr | input | ADDR_W | Byte address, bits 1:0 ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_rvalid | output | 1 | Read data valid, one cycle after the read strobe |
| bus_err | output | 1 | One-cycle pulse after an access to an unimplemented address |
| remap_active | output | 1 | Memory remap request, high while control bit 2 is zero |
| led_on | output | 1 | LED drive, control bit 0 |
| board_rst_req | output | 1 | One-cycle board reset request |

## Verification
A wrong lock comparison shows up one cycle after the next oscillator access: an ignored write reads back changed, or a keyed write reads back unchanged. A state machine in the wrong state shows on the very next cycle as a stray or missing read-valid or error pulse. A control register that drifts shows immediately on `remap_active` or `led_on`. A behavioural model in the bench compares every output on every clock, so each such fault is caught within one or two cycles of the access that exposes it.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

    localparam int DATA_W = 32;
    localparam int KEY_W  = 16;

    localparam logic [KEY_W-1:0]  UNLOCK_KEY  = 16'hA05F;
    localparam logic [DATA_W-1:0] ID_WORD     = 32'h411A3001;
    localparam logic [DATA_W-1:0] STAT_WORD   = 32'h00100000;
    localparam logic [DATA_W-1:0] OSC_RST     = 32'h01000048;
    localparam logic [DATA_W-1:0] AUX_RST     = 32'h0007FEFF;
    localparam logic [DATA_W-1:0] SDRAM_BASE  = 32'h00011122;
    localparam logic [DATA_W-1:0] INIT_RST    = 32'h00000112;

    // word offsets inside the low 0x100 bytes
    localparam logic [5:0] WO_ID     = 6'd0;
    localparam logic [5:0] WO_PROC   = 6'd1;
    localparam logic [5:0] WO_OSC    = 6'd2;
    localparam logic [5:0] WO_CTRL   = 6'd3;
    localparam logic [5:0] WO_STAT   = 6'd4;
    localparam logic [5:0] WO_LOCK   = 6'd5;
    localparam logic [5:0] WO_AUX    = 6'd7;
    localparam logic [5:0] WO_SDRAM  = 6'd8;
    localparam logic [5:0] WO_INIT   = 6'd9;
    localparam logic [5:0] WO_FA_SET = 6'd12;
    localparam logic [5:0] WO_FA_CLR = 6'd13;
    localparam logic [5:0] WO_FB_SET = 6'd14;
    localparam logic [5:0] WO_FB_CLR = 6'd15;

    typedef enum logic [1:0] {
        BUS_IDLE,
        BUS_RD_OK,
        BUS_RD_BAD,
        BUS_WR_BAD
    } bus_state_e;

    typedef enum logic [3:0] {
        SEL_ID, SEL_PROC, SEL_OSC, SEL_CTRL, SEL_STAT, SEL_LOCK, SEL_AUX,
        SEL_SDRAM, SEL_INIT, SEL_FA_SET, SEL_FA_CLR, SEL_FB_SET, SEL_FB_CLR,
        SEL_DESC, SEL_BLANK, SEL_NONE
    } reg_sel_e;

    function automatic logic [DATA_W-1:0] sdram_size_code(input int mem_mib);
        if (mem_mib >= 256)      return 32'h10;
        else if (mem_mib >= 128) return 32'h0C;
        else if (mem_mib >= 64)  return 32'h08;
        else if (mem_mib >= 32)  return 32'h04;
        else                     return 32'h00;
    endfunction

    function automatic logic [7:0] density_code(input int mem_mib);
        if (mem_mib >= 256)      return 8'd64;
        else if (mem_mib >= 128) return 8'd32;
        else if (mem_mib >= 64)  return 8'd16;
        else if (mem_mib >= 32)  return 8'd4;
        else                     return 8'd2;
    endfunction

    function automatic logic [7:0] desc_byte(input int idx, input int mem_mib);
        case (idx)
            0:  return 8'h80;
            1:  return 8'h08;
            2:  return 8'h04;
            3:  return 8'h0B;
            4:  return 8'h09;
            5:  return 8'h01;
            6:  return 8'h40;
            8:  return 8'h02;
            9:  return 8'hA0;
            10: return 8'hA0;
            13: return 8'h08;
            15: return 8'h01;
            16: return 8'h0E;
            17: return 8'h04;
            18: return 8'h1C;
            19: return 8'h01;
            20: return 8'h02;
            21: return 8'h20;
            22: return 8'hC0;
            27: return 8'h30;
            28: return 8'h28;
            29: return 8'h30;
            30: return 8'h28;
            31: return density_code(mem_mib);
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/sysctl_addr_decode.sv
module sysctl_addr_decode
    import sysctl_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int DESC_IDX_W = 5
) (
    input  logic [ADDR_W-1:0]     addr,
    output reg_sel_e              sel,
    output logic                  rd_legal,
    output logic                  wr_legal,
    output logic [DESC_IDX_W-1:0] desc_idx
);

    localparam int LOW_SPAN_W = 9;

    logic upper_zero;

    generate
        if (ADDR_W > LOW_SPAN_W) begin : g_upper
            assign upper_zero = (addr[ADDR_W-1:LOW_SPAN_W] == '0);
        end else begin : g_no_upper
            assign upper_zero = 1'b1;
        end
    endgenerate

    assign desc_idx = addr[DESC_IDX_W+1:2];

    always_comb begin
        sel = SEL_NONE;
        if (upper_zero) begin
            if (addr[8]) begin
                sel = addr[7] ? SEL_BLANK : SEL_DESC;
            end else begin
                unique case (addr[7:2])
                    WO_ID:     sel = SEL_ID;
                    WO_PROC:   sel = SEL_PROC;
                    WO_OSC:    sel = SEL_OSC;
                    WO_CTRL:   sel = SEL_CTRL;
                    WO_STAT:   sel = SEL_STAT;
                    WO_LOCK:   sel = SEL_LOCK;
                    WO_AUX:    sel = SEL_AUX;
                    WO_SDRAM:  sel = SEL_SDRAM;
                    WO_INIT:   sel = SEL_INIT;
                    WO_FA_SET: sel = SEL_FA_SET;
                    WO_FA_CLR: sel = SEL_FA_CLR;
                    WO_FB_SET: sel = SEL_FB_SET;
                    WO_FB_CLR: sel = SEL_FB_CLR;
                    default:   sel = SEL_NONE;
                endcase
            end
        end
    end

    always_comb begin
        unique case (sel)
            SEL_FA_CLR, SEL_FB_CLR, SEL_NONE: rd_legal = 1'b0;
            default:                          rd_legal = 1'b1;
        endcase
        unique case (sel)
            SEL_OSC, SEL_CTRL, SEL_LOCK, SEL_AUX, SEL_SDRAM, SEL_INIT,
            SEL_FA_SET, SEL_FA_CLR, SEL_FB_SET, SEL_FB_CLR: wr_legal = 1'b1;
            default:                                        wr_legal = 1'b0;
        endcase
    end

endmodule

// File: rtl/sysctl_regfile.sv
module sysctl_regfile
    import sysctl_pkg::*;
#(
    parameter int MEM_MIB    = 128,
    parameter int DESC_IDX_W = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_commit,
    input  reg_sel_e              sel,
    input  logic [DATA_W-1:0]     wdata,
    input  logic [DESC_IDX_W-1:0] desc_idx,
    output logic [DATA_W-1:0]     rd_word,
    output logic                  remap_active,
    output logic                  led_on,
    output logic                  board_rst_req,
    output logic [DATA_W-1:0]     osc_main,
    output logic [DATA_W-1:0]     osc_aux,
    output logic [KEY_W-1:0]      lock_key
);

    localparam logic [DATA_W-1:0] SDRAM_RST = SDRAM_BASE | sdram_size_code(MEM_MIB);
    localparam int CTRL_W = 3;

    logic [DATA_W-1:0] osc_q, aux_q, sdram_q, init_q, flag_a_q, flag_b_q;
    logic [KEY_W-1:0]  lock_q;
    logic [CTRL_W-1:0] ctrl_q;
    logic              brst_q;
    logic              unlocked;

    assign unlocked = (lock_q == UNLOCK_KEY);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            osc_q    <= OSC_RST;
            aux_q    <= AUX_RST;
            sdram_q  <= SDRAM_RST;
            init_q   <= INIT_RST;
            lock_q   <= '0;
            flag_a_q <= '0;
            flag_b_q <= '0;
            ctrl_q   <= '0;
            brst_q   <= 1'b0;
        end else begin
            brst_q <= wr_commit && (sel == SEL_CTRL) && wdata[3];
            if (wr_commit) begin
                unique case (sel)
                    SEL_OSC:    if (unlocked) osc_q <= wdata;
                    SEL_AUX:    if (unlocked) aux_q <= wdata;
                    SEL_LOCK:   lock_q   <= wdata[KEY_W-1:0];
                    SEL_CTRL:   ctrl_q   <= wdata[CTRL_W-1:0];
                    SEL_SDRAM:  sdram_q  <= wdata;
                    SEL_INIT:   init_q   <= wdata;
                    SEL_FA_SET: flag_a_q <= flag_a_q | wdata;
                    SEL_FA_CLR: flag_a_q <= flag_a_q & ~wdata;
                    SEL_FB_SET: flag_b_q <= flag_b_q | wdata;
                    SEL_FB_CLR: flag_b_q <= flag_b_q & ~wdata;
                    default:    ;
                endcase
            end
        end
    end

    always_comb begin
        unique case (sel)
            SEL_ID:     rd_word = ID_WORD;
            SEL_STAT:   rd_word = STAT_WORD;
            SEL_OSC:    rd_word = osc_q;
            SEL_AUX:    rd_word = aux_q;
            SEL_LOCK:   rd_word = {{(DATA_W-KEY_W-1){1'b0}}, unlocked, lock_q};
            SEL_CTRL:   rd_word = {{(DATA_W-CTRL_W){1'b0}}, ctrl_q};
            SEL_SDRAM:  rd_word = sdram_q;
            SEL_INIT:   rd_word = init_q;
            SEL_FA_SET: rd_word = flag_a_q;
            SEL_FB_SET: rd_word = flag_b_q;
            SEL_DESC:   rd_word = {{(DATA_W-8){1'b0}}, desc_byte(int'(desc_idx), MEM_MIB)};
            default:    rd_word = '0;
        endcase
    end

    assign remap_active  = ~ctrl_q[2];
    assign led_on        = ctrl_q[0];
    assign board_rst_req = brst_q;
    assign osc_main      = osc_q;
    assign osc_aux       = aux_q;
    assign lock_key      = lock_q;

endmodule

// File: rtl/sysctl_bus_fsm.sv
module sysctl_bus_fsm
    import sysctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic              rd_legal,
    input  logic              wr_legal,
    input  logic [DATA_W-1:0] rd_word,
    output logic              wr_commit,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid,
    output logic              err
);

    bus_state_e state_q, state_d;
    logic [DATA_W-1:0] rdata_q;

    assign wr_commit = wr_en && wr_legal;

    always_comb begin
        if (wr_en)      state_d = wr_legal ? BUS_IDLE  : BUS_WR_BAD;
        else if (rd_en) state_d = rd_legal ? BUS_RD_OK : BUS_RD_BAD;
        else            state_d = BUS_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= BUS_IDLE;
            rdata_q <= '0;
        end else begin
            state_q <= state_d;
            rdata_q <= (state_d == BUS_RD_OK) ? rd_word : '0;
        end
    end

    always_comb begin
        unique case (state_q)
            BUS_IDLE:   begin rvalid = 1'b0; err = 1'b0; end
            BUS_RD_OK:  begin rvalid = 1'b1; err = 1'b0; end
            BUS_RD_BAD: begin rvalid = 1'b1; err = 1'b1; end
            BUS_WR_BAD: begin rvalid = 1'b0; err = 1'b1; end
            default:    begin rvalid = 1'b0; err = 1'b0; end
        endcase
    end

    assign rdata = rdata_q;

endmodule

// File: rtl/sysctl_regblock.sv
module sysctl_regblock
    import sysctl_pkg::*;
#(
    parameter int ADDR_W  = 12,
    parameter int MEM_MIB = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_rvalid,
    output logic              bus_err,
    output logic              remap_active,
    output logic              led_on,
    output logic              board_rst_req
);

    localparam int DESC_IDX_W = 5;

    reg_sel_e                sel;
    logic                    rd_legal, wr_legal, wr_commit;
    logic [DESC_IDX_W-1:0]   desc_idx;
    logic [DATA_W-1:0]       rd_word;
    logic [DATA_W-1:0]       osc_main_w, osc_aux_w;
    logic [KEY_W-1:0]        lock_key_w;

    sysctl_addr_decode #(.ADDR_W(ADDR_W), .DESC_IDX_W(DESC_IDX_W)) u_dec (
        .addr     (bus_addr),
        .sel      (sel),
        .rd_legal (rd_legal),
        .wr_legal (wr_legal),
        .desc_idx (desc_idx)
    );

    sysctl_bus_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (bus_wr),
        .rd_en     (bus_rd),
        .rd_legal  (rd_legal),
        .wr_legal  (wr_legal),
        .rd_word   (rd_word),
        .wr_commit (wr_commit),
        .rdata     (bus_rdata),
        .rvalid    (bus_rvalid),
        .err       (bus_err)
    );

    sysctl_regfile #(.MEM_MIB(MEM_MIB), .DESC_IDX_W(DESC_IDX_W)) u_regs (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_commit     (wr_commit),
        .sel           (sel),
        .wdata         (bus_wdata),
        .desc_idx      (desc_idx),
        .rd_word       (rd_word),
        .remap_active  (remap_active),
        .led_on        (led_on),
        .board_rst_req (board_rst_req),
        .osc_main      (osc_main_w),
        .osc_aux       (osc_aux_w),
        .lock_key      (lock_key_w)
    );

endmodule

// File: rtl/sysctl_regblock_chk.sv
module sysctl_regblock_chk
    import sysctl_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic              bus_rvalid,
    input logic              bus_err,
    input logic              remap_active,
    input logic              led_on,
    input logic              board_rst_req,
    input logic [31:0]       osc_main,
    input logic [31:0]       osc_aux,
    input logic [15:0]       lock_key
);

    logic [ADDR_W-3:0] waddr;
    logic hit_osc, hit_aux, hit_ctrl, hit_lock;

    assign waddr    = bus_addr[ADDR_W-1:2];
    assign hit_osc  = (waddr == (ADDR_W-2)'(2));
    assign hit_ctrl = (waddr == (ADDR_W-2)'(3));
    assign hit_lock = (waddr == (ADDR_W-2)'(5));
    assign hit_aux  = (waddr == (ADDR_W-2)'(7));

    a_r1_read_answered: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_wr) |=> bus_rvalid);

    a_r1_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |=> !bus_rvalid);

    a_r11_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_rd && !bus_wr) |=> (!bus_rvalid && !bus_err));

    a_r3_unlocked_readback: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_wr && hit_lock && lock_key == UNLOCK_KEY) |=> (bus_rdata == 32'h0001A05F));

    a_r4_main_osc_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && hit_osc && lock_key != UNLOCK_KEY) |=> $stable(osc_main));

    a_r4_aux_osc_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && hit_aux && lock_key != UNLOCK_KEY) |=> $stable(osc_aux));

    a_r7_outputs_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> ($stable(remap_active) && $stable(led_on)));

    a_r8_reset_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && hit_ctrl && bus_wdata[3]) |=> board_rst_req);

    a_r8_reset_only_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> !board_rst_req);

endmodule

bind sysctl_regblock sysctl_regblock_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_wr        (bus_wr),
    .bus_rd        (bus_rd),
    .bus_addr      (bus_addr),
    .bus_wdata     (bus_wdata),
    .bus_rdata     (bus_rdata),
    .bus_rvalid    (bus_rvalid),
    .bus_err       (bus_err),
    .remap_active  (remap_active),
    .led_on        (led_on),
    .board_rst_req (board_rst_req),
    .osc_main      (osc_main_w),
    .osc_aux       (osc_aux_w),
    .lock_key      (lock_key_w)
);

// File: tb/sysctl_regblock_test.sv
`timescale 1ns/1ps
module sysctl_regblock_test;

    localparam int AW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          bus_rvalid, bus_err, remap_active, led_on, board_rst_req;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    sysctl_regblock #(.ADDR_W(AW), .MEM_MIB(128)) uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .bus_err(bus_err), .remap_active(remap_active),
        .led_on(led_on), .board_rst_req(board_rst_req)
    );

    // behavioural reference model
    int unsigned m_osc, m_aux, m_sdram, m_init, m_lock, m_fa, m_fb, m_ctrl;
    int unsigned e_rdata;
    bit e_rvalid, e_err, e_brst;
    byte unsigned table_b [32];

    initial begin
        foreach (table_b[i]) table_b[i] = 0;
        table_b[0] = 8'h80; table_b[1] = 8'h08; table_b[2] = 8'h04; table_b[3] = 8'h0B;
        table_b[4] = 8'h09; table_b[5] = 8'h01; table_b[6] = 8'h40; table_b[8] = 8'h02;
        table_b[9] = 8'hA0; table_b[10] = 8'hA0; table_b[13] = 8'h08; table_b[15] = 8'h01;
        table_b[16] = 8'h0E; table_b[17] = 8'h04; table_b[18] = 8'h1C; table_b[19] = 8'h01;
        table_b[20] = 8'h02; table_b[21] = 8'h20; table_b[22] = 8'hC0; table_b[27] = 8'h30;
        table_b[28] = 8'h28; table_b[29] = 8'h30; table_b[30] = 8'h28; table_b[31] = 8'd32;
    end

    function automatic bit model_keyed();
        return m_lock == 32'hA05F;
    endfunction

    task automatic model_write(input int unsigned a, input int unsigned d);
        if (a >= 32'h100) begin
            e_err = 1;
        end else begin
            case (a >> 2)
                2:  if (model_keyed()) m_osc = d;
                3:  begin m_ctrl = d & 7; e_brst = d[3]; end
                5:  m_lock = d & 32'hFFFF;
                7:  if (model_keyed()) m_aux = d;
                8:  m_sdram = d;
                9:  m_init = d;
                12: m_fa = m_fa | d;
                13: m_fa = m_fa & ~d;
                14: m_fb = m_fb | d;
                15: m_fb = m_fb & ~d;
                default: e_err = 1;
            endcase
        end
    endtask

    task automatic model_read(input int unsigned a);
        e_rvalid = 1;
        if (a >= 32'h200) e_err = 1;
        else if (a >= 32'h180) e_rdata = 0;
        else if (a >= 32'h100) e_rdata = table_b[(a - 32'h100) >> 2];
        else begin
            case (a >> 2)
                0:  e_rdata = 32'h411A3001;
                1:  e_rdata = 0;
                2:  e_rdata = m_osc;
                3:  e_rdata = m_ctrl;
                4:  e_rdata = 32'h00100000;
                5:  e_rdata = model_keyed() ? 32'h0001A05F : m_lock;
                7:  e_rdata = m_aux;
                8:  e_rdata = m_sdram;
                9:  e_rdata = m_init;
                12: e_rdata = m_fa;
                14: e_rdata = m_fb;
                default: e_err = 1;
            endcase
        end
    endtask

    always @(posedge clk) begin
        cycles = cycles + 1;
        e_rvalid = 0; e_rdata = 0; e_err = 0; e_brst = 0;
        if (!rst_n) begin
            m_osc = 32'h01000048; m_aux = 32'h0007FEFF; m_sdram = 32'h0001112E;
            m_init = 32'h112; m_lock = 0; m_fa = 0; m_fb = 0; m_ctrl = 0;
        end else if (bus_wr) begin
            model_write(32'(bus_addr), bus_wdata);
        end else if (bus_rd) begin
            model_read(32'(bus_addr));
        end
    end

    task automatic check(input bit ok, input string tag, input int unsigned act, input int unsigned exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (cycles > 0) begin
            check(bus_rvalid == e_rvalid, "R1 rvalid", 32'(bus_rvalid), 32'(e_rvalid));
            check(bus_rdata == e_rdata, "R1 rdata", bus_rdata, e_rdata);
            check(bus_err == e_err, "R11 err", 32'(bus_err), 32'(e_err));
            check(board_rst_req == e_brst, "R8 reset request", 32'(board_rst_req), 32'(e_brst));
            check(led_on == m_ctrl[0], "R7 led", 32'(led_on), 32'(m_ctrl[0]));
            check(remap_active == !m_ctrl[2], "R7 remap", 32'(remap_active), 32'(!m_ctrl[2]));
        end
    end

    task automatic wr(input int unsigned a, input int unsigned d);
        @(negedge clk);
        bus_wr = 1; bus_addr = AW'(a); bus_wdata = d;
        @(negedge clk);
        bus_wr = 0; bus_wdata = 0;
    endtask

    task automatic rd_chk(input int unsigned a, input int unsigned exp, input bit exp_err, input string tag);
        @(negedge clk);
        bus_rd = 1; bus_addr = AW'(a);
        @(negedge clk);
        bus_rd = 0;
        check(bus_rvalid && bus_rdata == exp, tag, bus_rdata, exp);
        check(bus_err == exp_err, tag, 32'(bus_err), 32'(exp_err));
    endtask

    task automatic wr_chk_err(input int unsigned a, input int unsigned d, input string tag);
        @(negedge clk);
        bus_wr = 1; bus_addr = AW'(a); bus_wdata = d;
        @(negedge clk);
        bus_wr = 0;
        check(bus_err == 1'b1, tag, 32'(bus_err), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R2 reset state
        check(remap_active == 1'b1 && led_on == 1'b0 && board_rst_req == 1'b0, "R2 outputs",
              {29'd0, remap_active, led_on, board_rst_req}, 32'h4);
        check(bus_rvalid == 1'b0, "R2 rvalid", 32'(bus_rvalid), 0);
        rd_chk(32'h08, 32'h01000048, 0, "R2 osc reset");
        rd_chk(32'h1C, 32'h0007FEFF, 0, "R2 aux reset");
        rd_chk(32'h24, 32'h00000112, 0, "R2 init reset");
        rd_chk(32'h14, 32'h0, 0, "R2 lock reset");
        rd_chk(32'h30, 32'h0, 0, "R2 flags reset");
        rd_chk(32'h20, 32'h0001112E, 0, "R10 sdram reset");
        // R6 constants
        rd_chk(32'h00, 32'h411A3001, 0, "R6 id");
        rd_chk(32'h04, 32'h0, 0, "R6 proc");
        rd_chk(32'h10, 32'h00100000, 0, "R6 status");
        wr_chk_err(32'h00, 32'hFFFFFFFF, "R6 write to constant");
        rd_chk(32'h00, 32'h411A3001, 0, "R6 id unchanged");
        // R4 locked writes ignored
        wr(32'h08, 32'hDEADBEEF);
        rd_chk(32'h08, 32'h01000048, 0, "R4 locked osc");
        wr(32'h14, 32'h1234A05F);
        rd_chk(32'h14, 32'h0001A05F, 0, "R3 unlocked readback");
        wr(32'h08, 32'hDEADBEEF);
        rd_chk(32'h08, 32'hDEADBEEF, 0, "R4 keyed osc");
        wr(32'h1C, 32'h12345678);
        rd_chk(32'h1C, 32'h12345678, 0, "R4 keyed aux");
        wr(32'hFFFF0001, 32'h0);
        wr(32'h14, 32'hFFFF0001);
        rd_chk(32'h14, 32'h00000001, 0, "R3 low half kept");
        wr(32'h1C, 32'h0);
        rd_chk(32'h1C, 32'h12345678, 0, "R4 relocked aux");
        // R5 flags
        wr(32'h30, 32'h0000F0F0);
        wr(32'h30, 32'h0000000F);
        rd_chk(32'h30, 32'h0000F0FF, 0, "R5 set accumulates");
        wr(32'h34, 32'h000000F0);
        rd_chk(32'h30, 32'h0000F00F, 0, "R5 clear");
        wr(32'h38, 32'hAAAA5555);
        wr(32'h3C, 32'h0000FFFF);
        rd_chk(32'h38, 32'hAAAA0000, 0, "R5 second word");
        rd_chk(32'h30, 32'h0000F00F, 0, "R5 words independent");
        rd_chk(32'h34, 32'h0, 1, "R11 clear alias read");
        // R7 control
        wr(32'h0C, 32'h5);
        check(led_on == 1'b1 && remap_active == 1'b0, "R7 outputs after write",
              {30'd0, led_on, remap_active}, 32'h2);
        rd_chk(32'h0C, 32'h5, 0, "R7 readback");
        wr(32'h0C, 32'h1);
        check(remap_active == 1'b1, "R7 remap back", 32'(remap_active), 1);
        // R8 reset request
        @(negedge clk);
        bus_wr = 1; bus_addr = AW'(32'h0C); bus_wdata = 32'h9;
        @(negedge clk);
        bus_wr = 0;
        check(board_rst_req == 1'b1, "R8 pulse", 32'(board_rst_req), 1);
        @(negedge clk);
        check(board_rst_req == 1'b0, "R8 single cycle", 32'(board_rst_req), 0);
        rd_chk(32'h0C, 32'h1, 0, "R8 bit3 not stored");
        // R9 descriptor window
        rd_chk(32'h100, 32'h80, 0, "R9 entry0");
        rd_chk(32'h104, 32'h08, 0, "R9 entry1");
        rd_chk(32'h124, 32'hA0, 0, "R9 entry9");
        rd_chk(32'h17C, 32'd32, 0, "R9 density");
        rd_chk(32'h180, 32'h0, 0, "R9 blank low");
        rd_chk(32'h1FC, 32'h0, 0, "R9 blank high");
        wr_chk_err(32'h104, 32'h1, "R9 window write");
        // R10 sdram / init
        wr(32'h20, 32'h12345678);
        rd_chk(32'h20, 32'h12345678, 0, "R10 sdram rw");
        wr(32'h24, 32'h00000ABC);
        rd_chk(32'h24, 32'h00000ABC, 0, "R10 init rw");
        // R11 holes
        rd_chk(32'h18, 32'h0, 1, "R11 hole read");
        wr_chk_err(32'h28, 32'h1, "R11 hole write");
        rd_chk(32'h200, 32'h0, 1, "R11 high read");
        wr_chk_err(32'h230, 32'h1, "R11 high write");
        // R1 simultaneous strobes
        @(negedge clk);
        bus_wr = 1; bus_rd = 1; bus_addr = AW'(32'h30); bus_wdata = 32'h00010000;
        @(negedge clk);
        bus_wr = 0; bus_rd = 0;
        check(bus_rvalid == 1'b0, "R1 write wins", 32'(bus_rvalid), 0);
        rd_chk(32'h30, 32'h0001F00F, 0, "R1 write performed");
        repeat (3) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #100000;
        failures++;
        $display("FAIL watchdog expired, actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule